// File: doc/BRIEF.md
# Per-Lane Selectable Event Counter

This block holds one event counter for a multi-lane serial link. Each lane presents a row of one-cycle strobes: acknowledge and flow-control update packets in each direction, nullified and duplicate packets, and each transaction packet type sent or received. Software picks one of these sources with a 12-bit event code and a 4-bit lane number. It starts and stops counting with a 3-bit command code, and it zeroes the count with a 2-bit clear code. All of these go through one control word. The running count is read back through a data word.

Only one counter exists and it raises no interrupt. Event strobes are matched against the selection in the same cycle and added at the next clock edge. A small two-state machine holds the run state. ST_IDLE moves to ST_COUNTING on the start command (T_START). ST_COUNTING moves back to ST_IDLE on the stop command (T_STOP). Every other command keeps the current state (T_HOLD). The clear command is a one-cycle pulse. It is not stored.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset the count reads 0, the block is in ST_IDLE, and the control word reads 0.
- R2: A control-word write (offset 0x8) with enable command 3 in bits 4:2 enters ST_COUNTING at that edge, and status bit 7 of the control word then reads 1.
- R3: A control-word write with enable command 1 enters ST_IDLE at that edge. After that the count holds its value whatever the strobes do, and status bit 7 reads 0.
- R4: Enable command values other than 1 and 3 leave the run state unchanged.
- R5: In ST_COUNTING the count rises by exactly one on each edge where the selected strobe is high. Counting takes effect from the edge after the start write.
- R6: Clear command 1 in bits 1:0 zeroes the count at the write edge and wins over an event on that edge. Clear values 0, 2 and 3 do nothing. The clear field always reads back 0.
- R7: Event codes 0x600 to 0x606 select the seven data-link events (strobe index 0 to 6). Codes 0x700 to 0x717 select the 24 transaction events (strobe index 7 to 30). The strobe for lane L and index E is bit L*31+E of the strobe input.
- R8: An event code outside those ranges, or a lane number of NUM_LANES or more, selects a source that never counts.
- R9: The count wraps modulo 2^CNT_W (32 by default).
- R10: The data word at offset 0xC is read-only, and writes to it change nothing. Reads from any other offset return 0.
- R11: The control word reads back the event code in bits 27:16, the lane in bits 11:8 and the status in bit 7. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rd_addr | input | ADDR_W | Read byte offset |
| reg_rdata | output | 32 | Read data, combinational from reg_rd_addr |
| evt_strobe | input | NUM_LANES*31 | Per-lane event strobes, lane-major |

## Verification
The bench builds the block with NUM_LANES = 4 and CNT_W = 8. With four lanes, lane numbers 4 to 15 are out of range, so the zero-source path for a bad lane can be reached. With an 8-bit counter, a run of 258 strobes shows the modular wrap that a 32-bit counter would never reach in a short run. The stimulus table covers codes at both ends of each code range, and it includes cases where the lane is wrong or the event is wrong.

// File: rtl/lane_evt_pkg.sv
package lane_evt_pkg;

    localparam int REG_W      = 32;
    localparam int EVT_CODE_W = 12;
    localparam int LANE_SEL_W = 4;

    localparam int DLL_EVT_N  = 7;
    localparam int TLP_EVT_N  = 24;
    localparam int EVT_N      = DLL_EVT_N + TLP_EVT_N;

    localparam logic [EVT_CODE_W-1:0] DLL_BASE = 12'h600;
    localparam logic [EVT_CODE_W-1:0] TLP_BASE = 12'h700;

    localparam int OFS_CTL  = 8;
    localparam int OFS_DATA = 12;

    localparam int SEL_LSB  = 16;
    localparam int LANE_LSB = 8;
    localparam int STAT_BIT = 7;
    localparam int EN_LSB   = 2;
    localparam int CLR_LSB  = 0;

    localparam logic [2:0] EN_ON  = 3'd3;
    localparam logic [2:0] EN_OFF = 3'd1;
    localparam logic [1:0] CLR_GO = 2'd1;

    typedef enum logic {
        ST_IDLE,
        ST_COUNTING
    } run_state_t;

    function automatic logic [EVT_CODE_W-1:0] evt_code(input int idx);
        if (idx < DLL_EVT_N)
            return DLL_BASE + EVT_CODE_W'(idx);
        else
            return TLP_BASE + EVT_CODE_W'(idx - DLL_EVT_N);
    endfunction

endpackage

// File: rtl/lane_evt_select.sv
module lane_evt_select
    import lane_evt_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LANES*EVT_N-1:0]    evt_strobe,
    input  logic [EVT_CODE_W-1:0]         evt_sel,
    input  logic [LANE_SEL_W-1:0]         lane_sel,
    output logic                          src_hit
);

    localparam int SRC_N = NUM_LANES * EVT_N;

    logic [SRC_N-1:0] hit;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        for (genvar e = 0; e < EVT_N; e++) begin : g_evt
            assign hit[l*EVT_N+e] = evt_strobe[l*EVT_N+e]
                                 && (int'(lane_sel) == l)
                                 && (evt_sel == evt_code(e));
        end
    end

    assign src_hit = |hit;

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R5

    AST_BAD_LANE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lane_sel) >= NUM_LANES) |-> !src_hit); // R8

endmodule

// File: rtl/lane_evt_ctrl.sv
module lane_evt_ctrl
    import lane_evt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_we,
    input  logic [REG_W-1:0]       wdata,
    output logic [EVT_CODE_W-1:0]  evt_sel,
    output logic [LANE_SEL_W-1:0]  lane_sel,
    output logic                   counting,
    output logic                   clr_go
);

    run_state_t state_q, state_d;
    logic [2:0] en_cmd;
    logic [1:0] clr_cmd;

    assign en_cmd  = wdata[EN_LSB +: 3];
    assign clr_cmd = wdata[CLR_LSB +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            evt_sel  <= '0;
            lane_sel <= '0;
        end else begin
            state_q <= state_d;
            if (ctl_we) begin
                evt_sel  <= wdata[SEL_LSB +: EVT_CODE_W];
                lane_sel <= wdata[LANE_LSB +: LANE_SEL_W];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (ctl_we && en_cmd == EN_ON)  state_d = ST_COUNTING;
            ST_COUNTING: if (ctl_we && en_cmd == EN_OFF) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        counting = (state_q == ST_COUNTING);
        clr_go   = ctl_we && (clr_cmd == CLR_GO);
    end

    AST_TURN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && en_cmd == EN_ON) |=> counting); // R2

    AST_TURN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && en_cmd == EN_OFF) |=> !counting); // R3

    AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctl_we && (en_cmd == EN_ON || en_cmd == EN_OFF))) |=> $stable(counting)); // R4

endmodule

// File: rtl/lane_evt_count.sv
module lane_evt_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_go,
    input  logic             counting,
    input  logic             src_hit,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr_go)
            count <= '0;
        else if (counting && src_hit)
            count <= count + CNT_W'(1);
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> (count == '0)); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_go && counting && src_hit) |=> (count == $past(count) + CNT_W'(1))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_go && !counting) |=> $stable(count)); // R3

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_go && counting && src_hit && count == '1) |=> (count == '0)); // R9

endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
    import lane_evt_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_wr_addr,
    input  logic [31:0]                reg_wdata,
    input  logic [ADDR_W-1:0]          reg_rd_addr,
    output logic [31:0]                reg_rdata,
    input  logic [NUM_LANES*EVT_N-1:0] evt_strobe
);

    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

    logic                  ctl_we;
    logic [EVT_CODE_W-1:0] evt_sel;
    logic [LANE_SEL_W-1:0] lane_sel;
    logic                  counting;
    logic                  clr_go;
    logic                  src_hit;
    logic [CNT_W-1:0]      count;
    logic [REG_W-1:0]      ctl_word;

    assign ctl_we = reg_we && (reg_wr_addr == A_CTL);

    lane_evt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .wdata    (reg_wdata),
        .evt_sel  (evt_sel),
        .lane_sel (lane_sel),
        .counting (counting),
        .clr_go   (clr_go)
    );

    lane_evt_select #(.NUM_LANES(NUM_LANES)) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_strobe (evt_strobe),
        .evt_sel    (evt_sel),
        .lane_sel   (lane_sel),
        .src_hit    (src_hit)
    );

    lane_evt_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_go   (clr_go),
        .counting (counting),
        .src_hit  (src_hit),
        .count    (count)
    );

    always_comb begin
        ctl_word = '0;
        ctl_word[SEL_LSB +: EVT_CODE_W]  = evt_sel;
        ctl_word[LANE_LSB +: LANE_SEL_W] = lane_sel;
        ctl_word[STAT_BIT]               = counting;
    end

    always_comb begin
        unique case (reg_rd_addr)
            A_CTL:   reg_rdata = ctl_word;
            A_DATA:  reg_rdata = REG_W'(count);
            default: reg_rdata = '0;
        endcase
    end

    AST_DATA_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wr_addr == A_DATA && !counting) |=> $stable(count)); // R10

endmodule

// File: tb/test_lane_evt_counter.sv
module test_lane_evt_counter;
    import lane_evt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 4;
    localparam int CW         = 8;
    localparam int AW         = 8;
    localparam int NV         = 9;

    // {sel code 12, sel lane 4, drive lane 4, drive idx 8, cycles 8, expected 8}
    localparam logic [43:0] VEC [NV] = '{
        {12'h600, 4'd0, 4'd0, 8'd0,  8'd5, 8'd5},
        {12'h606, 4'd2, 4'd2, 8'd6,  8'd3, 8'd3},
        {12'h700, 4'd1, 4'd1, 8'd7,  8'd4, 8'd4},
        {12'h717, 4'd3, 4'd3, 8'd30, 8'd6, 8'd6},
        {12'h70B, 4'd0, 4'd0, 8'd18, 8'd2, 8'd2},
        {12'h601, 4'd1, 4'd2, 8'd1,  8'd4, 8'd0},
        {12'h602, 4'd0, 4'd0, 8'd3,  8'd4, 8'd0},
        {12'h607, 4'd0, 4'd0, 8'd6,  8'd3, 8'd0},
        {12'h600, 4'd9, 4'd1, 8'd0,  8'd3, 8'd0}
    };

    logic              clk = 0;
    logic              rst_n = 0;
    logic              reg_we = 0;
    logic [AW-1:0]     reg_wr_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [AW-1:0]     reg_rd_addr = '0;
    logic [31:0]       reg_rdata;
    logic [NL*EVT_N-1:0] evt_strobe = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_evt_counter #(.NUM_LANES(NL), .CNT_W(CW), .ADDR_W(AW)) i_lane_evt_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_wr_addr (reg_wr_addr),
        .reg_wdata   (reg_wdata),
        .reg_rd_addr (reg_rd_addr),
        .reg_rdata   (reg_rdata),
        .evt_strobe  (evt_strobe)
    );

    function automatic logic [31:0] ctl(input logic [11:0] code, input logic [3:0] lane,
                                        input logic [2:0] en, input logic [1:0] clr);
        return {4'h0, code, 4'h0, lane, 3'b000, en, clr};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_wr_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int lane, input int idx, input int n);
        @(negedge clk);
        evt_strobe[lane*EVT_N+idx] = 1'b1;
        repeat (n) @(negedge clk);
        evt_strobe = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(8'h08, d); check("R1 control after reset", d, 32'h0);
        rd(8'h0C, d); check("R1 count after reset", d, 32'h0);

        // R7 R8 R5 table walk
        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            v = VEC[i];
            wr(8'h08, ctl(v[43:32], v[31:28], EN_ON, CLR_GO));
            pulse(int'(v[27:24]), int'(v[23:16]), int'(v[15:8]));
            wr(8'h08, ctl(v[43:32], v[31:28], EN_OFF, 2'd0));
            rd(8'h0C, d);
            check($sformatf("R7/R8 vector %0d count", i), d, {24'h0, v[7:0]});
        end

        // R11 R2 readback with status and self-clearing clear field
        wr(8'h08, ctl(12'h70B, 4'd2, EN_ON, CLR_GO));
        rd(8'h08, d); check("R11 R2 control readback", d, 32'h070B_0280);

        // R3 stop holds the count
        wr(8'h08, ctl(12'h600, 4'd0, EN_ON, CLR_GO));
        pulse(0, 0, 3);
        wr(8'h08, ctl(12'h600, 4'd0, EN_OFF, 2'd0));
        pulse(0, 0, 4);
        rd(8'h0C, d); check("R3 count held after stop", d, 32'd3);
        rd(8'h08, d); check("R3 status off", d, 32'h0600_0000);

        // R4 other enable codes keep state
        wr(8'h08, ctl(12'h600, 4'd0, 3'd2, 2'd0));
        pulse(0, 0, 2);
        rd(8'h0C, d); check("R4 code 2 keeps idle", d, 32'd3);
        wr(8'h08, ctl(12'h600, 4'd0, EN_ON, 2'd0));
        pulse(0, 0, 2);
        rd(8'h0C, d); check("R2 restart without clear", d, 32'd5);
        wr(8'h08, ctl(12'h600, 4'd0, 3'd5, 2'd0));
        wr(8'h08, ctl(12'h600, 4'd0, 3'd0, 2'd0));
        pulse(0, 0, 2);
        rd(8'h0C, d); check("R4 codes 5 and 0 keep counting", d, 32'd7);
        rd(8'h08, d); check("R4 status still on", d, 32'h0600_0080);

        // R6 non-clear codes do nothing
        wr(8'h08, ctl(12'h600, 4'd0, 3'd0, 2'd2));
        wr(8'h08, ctl(12'h600, 4'd0, 3'd0, 2'd3));
        rd(8'h0C, d); check("R6 clear codes 2 and 3 ignored", d, 32'd7);

        // R6 clear wins over same-edge event
        @(negedge clk);
        evt_strobe[0] = 1'b1;
        reg_we = 1; reg_wr_addr = 8'h08; reg_wdata = ctl(12'h600, 4'd0, 3'd0, CLR_GO);
        @(negedge clk);
        reg_we = 0; evt_strobe = '0;
        reg_rd_addr = 8'h0C; #1;
        check("R6 clear beats event", reg_rdata, 32'd0);
        rd(8'h08, d); check("R6 still counting after clear", d, 32'h0600_0080);

        // R5 counting starts the edge after the start write
        wr(8'h08, ctl(12'h600, 4'd0, EN_OFF, 2'd0));
        @(negedge clk);
        evt_strobe[0] = 1'b1;
        reg_we = 1; reg_wr_addr = 8'h08; reg_wdata = ctl(12'h600, 4'd0, EN_ON, CLR_GO);
        @(negedge clk);
        reg_we = 0; reg_rd_addr = 8'h0C; #1;
        check("R5 no count on start edge", reg_rdata, 32'd0);
        @(negedge clk); #1;
        check("R5 first count next edge", reg_rdata, 32'd1);
        evt_strobe = '0;

        // R10 data word read-only, unmapped reads zero
        wr(8'h0C, 32'h0000_0055);
        rd(8'h0C, d); check("R10 data write ignored", d, 32'd1);
        rd(8'h04, d); check("R10 unmapped read zero", d, 32'd0);

        // R9 wrap of 8-bit counter
        wr(8'h08, ctl(12'h601, 4'd1, EN_ON, CLR_GO));
        pulse(1, 1, 258);
        rd(8'h0C, d); check("R9 wrap 258 mod 256", d, 32'd2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule